// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block decodes bus cycles on a 24-bit address bus against a bank of programmable channels. Each channel holds a base address, a block size, an address-space qualifier, an interrupt level for CPU-space cycles, a wait-state code, a strobe timing choice, a byte-lane restriction and a port width. When a bus cycle starts with the address strobe low, every channel whose qualifiers all match drives its active-low select output.

The block also ends the cycle. The lowest-numbered matching channel supplies the termination. A code of 0 to 13 inserts that many wait states before the block returns the port-size acknowledge. A fast code returns the acknowledge at once. An external code leaves the acknowledge lines idle, so that the addressed device can answer on its own.

Channels are programmed through a single write port, one channel per write. All outputs are registered and clear in the clock after the address strobe rises.

Top module: `csgen_top`

## Requirements
- R1: After reset every channel is disabled. No bus cycle then asserts a select, and `dsack_n` stays 2'b11.
- R2: A configuration word holds these fields: [28:16] base (address bits 23:11), [15:13] block size, [12:11] space, [10:8] level, [7:4] termination code, [3] data-strobe timing, [2:1] lanes and [0] 16-bit port. Block codes 0 to 7 select sizes 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M. Each size compares only address bits 23 down to 11, 13, 14, 16, 17, 18, 19 and 20 respectively. Base bits below the compared range are ignored.
- R3: Space 00 matches only CPU-space cycles (fc = 3'b111). Space 01 matches non-CPU cycles with fc[2]=0 (user). Space 10 matches non-CPU cycles with fc[2]=1 (supervisor). Space 11 matches any non-CPU cycle.
- R4: In CPU space a level of 000 matches any cycle level. Any other level matches only a cycle with addr[3:1] equal to it.
- R5: Let k0 be the first clock edge that samples the address strobe low. For termination codes N = 0 to 13, the acknowledge becomes valid after edge k0+N+1 and holds until the strobe rises.
- R6: Code 14 gives the acknowledge after edge k0. Code 15 never drives the acknowledge.
- R7: `dsack_n` is 2'b01 for a 16-bit port and 2'b10 for an 8-bit port, and is 2'b11 when idle. It is never 2'b00.
- R8: A channel with data-strobe timing asserts its select only at edges that sample `ds_n` low. An address-strobe-timed channel asserts its select from k0.
- R9: Lanes 01 require `byte_lo`, lanes 10 require `byte_hi`, and lanes 11 accept either lane.
- R10: A channel with lanes 00 is disabled. It never asserts its select and never supplies an acknowledge.
- R11: When several channels match, all of their selects assert. The acknowledge timing and port width come from the lowest-numbered matching channel.
- R12: Selects and the acknowledge return high after the first edge that samples `as_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | $clog2(NCH) | Channel being written |
| cfg_wdata | input | 29 | Configuration word |
| addr | input | 24 | Bus address |
| fc | input | 3 | Function code (fc[2] supervisor, 3'b111 CPU space) |
| byte_hi | input | 1 | Cycle uses the upper byte lane |
| byte_lo | input | 1 | Cycle uses the lower byte lane |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| cs_n | output | NCH | Select per channel, active low |
| dsack_n | output | 2 | Acknowledge pair {ack1, ack0}, active low |

## Verification
The bench sweeps all eight block sizes. In each, it places base garbage below the compared range and probes an address just inside the block and one with the lowest compared bit flipped, which separates a correct mask from one that is a bit too wide or too narrow. It crosses all four space codes with user, supervisor and CPU function codes, and all eight level codes with cycle levels 1 to 7, to tell the wildcard level apart from exact matching. It measures acknowledge latency for all sixteen termination codes and alternates the port width to check the code pair. Lane, strobe-timing, disabled-channel and overlapping-channel cases show that qualification, priority and release each act on their own.

// File: rtl/csgen_pkg.sv
// Package for the chip-select generator: configuration record and decode helpers.
// Assumes a 24-bit address bus whose smallest decoded block is 2K.
package csgen_pkg;
    localparam int ADDR_W = 24;
    localparam int LSB_MIN = 11;
    localparam int BASE_W = ADDR_W - LSB_MIN;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [2:0]        blk;
        logic [1:0]        space;
        logic [2:0]        lvl;
        logic [3:0]        term;
        logic              ds_timed;
        logic [1:0]        lanes;
        logic              port16;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam logic [3:0] TERM_FAST = 4'd14;
    localparam logic [3:0] TERM_EXT  = 4'd15;

    // Lowest compared address bit for a block-size code.
    function automatic int blk_lsb(input logic [2:0] code);
        case (code)
            3'd0: blk_lsb = 11;
            3'd1: blk_lsb = 13;
            3'd2: blk_lsb = 14;
            3'd3: blk_lsb = 16;
            3'd4: blk_lsb = 17;
            3'd5: blk_lsb = 18;
            3'd6: blk_lsb = 19;
            default: blk_lsb = 20;
        endcase
    endfunction
endpackage

// File: rtl/cs_regfile.sv
// Configuration storage: one record per channel, written one at a time.
// Assumes writes are not made in the middle of a bus cycle. Reset disables all channels.
module cs_regfile #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [CHW-1:0]           ch,
    input  logic [csgen_pkg::CFG_W-1:0] wdata,
    output csgen_pkg::cfg_t          cfg [NCH]
);
    // Hold each channel record; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) cfg[i] <= '0;
        end else if (we) begin
            cfg[ch] <= csgen_pkg::cfg_t'(wdata);
        end
    end
endmodule

// File: rtl/cs_match.sv
// One channel decoder. It qualifies the cycle on address block, space, level and lanes,
// and registers the active-low select with the chosen strobe timing.
// Assumes addr, fc and the lanes stay stable while the address strobe is low.
module cs_match (
    input  logic                  clk,
    input  logic                  rst_n,
    input  csgen_pkg::cfg_t       cfg,
    input  logic [csgen_pkg::ADDR_W-1:0] addr,
    input  logic [2:0]            fc,
    input  logic                  byte_hi,
    input  logic                  byte_lo,
    input  logic                  as_n,
    input  logic                  ds_n,
    output logic                  hit,
    output logic                  cs_n_q
);
    import csgen_pkg::*;

    logic [BASE_W-1:0] mask;
    logic addr_ok, space_ok, lvl_ok, lane_ok, cpu_cyc;

    // Build the compare mask from the block size and compare the upper address bits.
    always_comb begin
        for (int j = 0; j < BASE_W; j++)
            mask[j] = ((j + LSB_MIN) >= blk_lsb(cfg.blk));
        addr_ok = (((addr[ADDR_W-1:LSB_MIN] ^ cfg.base) & mask) == '0);
    end

    // Qualify the cycle on space, interrupt level and byte lanes.
    always_comb begin
        cpu_cyc = (fc == 3'b111);
        case (cfg.space)
            2'b00: space_ok = cpu_cyc;
            2'b01: space_ok = !cpu_cyc && !fc[2];
            2'b10: space_ok = !cpu_cyc && fc[2];
            default: space_ok = !cpu_cyc;
        endcase
        lvl_ok  = (cfg.space != 2'b00) || (cfg.lvl == 3'd0) || (cfg.lvl == addr[3:1]);
        lane_ok = (cfg.lanes[0] && byte_lo) || (cfg.lanes[1] && byte_hi);
        hit     = addr_ok && space_ok && lvl_ok && lane_ok;
    end

    // Register the select with address- or data-strobe timing.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_n_q <= 1'b1;
        else        cs_n_q <= !(!as_n && hit && (!cfg.ds_timed || !ds_n));
    end

    // R12
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> cs_n_q);
    // R8
    cs_ds_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.ds_timed && ds_n) |=> cs_n_q);
    // R10
    cs_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.lanes == 2'b00) |=> cs_n_q);
endmodule

// File: rtl/cs_term.sv
// Cycle termination. It picks the lowest-numbered matching channel at the start of a
// cycle, counts its wait states and drives the port-size acknowledge until the strobe rises.
// Assumes the matches are stable while the address strobe is low.
module cs_term #(
    parameter int NCH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  csgen_pkg::cfg_t cfg [NCH],
    input  logic [NCH-1:0]  hit,
    input  logic            as_n,
    output logic [1:0]      dsack_n
);
    import csgen_pkg::*;

    logic       act_q, armed_q, ack_q, p16_q, ext_q;
    logic [3:0] cnt_q;
    logic       any_hit;
    logic [3:0] w_term;
    logic       w_p16;

    // Priority pick: the lowest-numbered matching channel wins.
    always_comb begin
        any_hit = 1'b0;
        w_term  = 4'd0;
        w_p16   = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                w_term  = cfg[i].term;
                w_p16   = cfg[i].port16;
            end
        end
    end

    // Cycle tracking, wait-state countdown and acknowledge generation.
    always_ff @(posedge clk) begin
        if (!rst_n || as_n) begin
            act_q <= 1'b0; armed_q <= 1'b0; ack_q <= 1'b0;
            ext_q <= 1'b0; cnt_q <= 4'd0; p16_q <= 1'b0;
        end else if (!act_q) begin
            act_q <= 1'b1;
            p16_q <= w_p16;
            cnt_q <= w_term;
            ext_q   <= any_hit && (w_term == TERM_EXT);
            ack_q   <= any_hit && (w_term == TERM_FAST);
            armed_q <= any_hit && (w_term < TERM_FAST);
        end else if (armed_q) begin
            if (cnt_q == 4'd0) begin
                ack_q   <= 1'b1;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 4'd1;
            end
        end
    end

    assign dsack_n = !ack_q ? 2'b11 : (p16_q ? 2'b01 : 2'b10);

    // R7
    dsack_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsack_n != 2'b00);
    // R12
    dsack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (dsack_n == 2'b11));
    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cnt_q != 4'd0) |=> (dsack_n == 2'b11));
    // R6
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && ext_q) |-> (dsack_n == 2'b11));
endmodule

// File: rtl/csgen_top.sv
// Chip-select generator top: configuration storage, one decoder per channel and a
// shared termination unit. Assumes a single bus master and stable cycle qualifiers.
module csgen_top #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CHW-1:0]              cfg_ch,
    input  logic [csgen_pkg::CFG_W-1:0] cfg_wdata,
    input  logic [csgen_pkg::ADDR_W-1:0] addr,
    input  logic [2:0]                  fc,
    input  logic                        byte_hi,
    input  logic                        byte_lo,
    input  logic                        as_n,
    input  logic                        ds_n,
    output logic [NCH-1:0]              cs_n,
    output logic [1:0]                  dsack_n
);
    csgen_pkg::cfg_t cfg_q [NCH];
    logic [NCH-1:0]  hit;

    cs_regfile #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .ch(cfg_ch),
        .wdata(cfg_wdata), .cfg(cfg_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cs_match u_match (
            .clk(clk), .rst_n(rst_n), .cfg(cfg_q[g]), .addr(addr), .fc(fc),
            .byte_hi(byte_hi), .byte_lo(byte_lo), .as_n(as_n), .ds_n(ds_n),
            .hit(hit[g]), .cs_n_q(cs_n[g])
        );
    end

    cs_term #(.NCH(NCH)) u_term (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .hit(hit),
        .as_n(as_n), .dsack_n(dsack_n)
    );
endmodule

// File: tb/tb_csgen_top.sv
// Self-checking bench: sweeps block sizes, spaces, levels, termination codes and lanes.
module tb_csgen_top;
    localparam int NCH = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_ch = '0;
    logic [28:0] cfg_wdata = '0;
    logic [23:0] addr = '0;
    logic [2:0] fc = 3'd5;
    logic byte_hi = 1'b1, byte_lo = 1'b1, as_n = 1'b1, ds_n = 1'b1;
    logic [NCH-1:0] cs_n;
    logic [1:0] dsack_n;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    csgen_top #(.NCH(NCH)) dut (.*);

    initial begin
        #(200000 * 5);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [28:0] mk(input logic [23:0] b, input logic [2:0] blk,
        input logic [1:0] sp, input logic [2:0] lv, input logic [3:0] tm,
        input bit dst, input logic [1:0] ln, input bit p16);
        mk = {b[23:11], blk, sp, lv, tm, dst, ln, p16};
    endfunction

    task automatic wr(input int ch, input logic [28:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NCH; i++) wr(i, '0);
    endtask

    // One bus cycle. lat: edges from k0 until the acknowledge is seen (0 = never).
    task automatic cyc(input logic [23:0] a, input logic [2:0] f, input bit hi, input bit lo,
        input bit ds_late, output int lat, output logic [NCH-1:0] cs1,
        output logic [NCH-1:0] cs2, output logic [1:0] code);
        @(negedge clk);
        addr = a; fc = f; byte_hi = hi; byte_lo = lo; as_n = 1'b0; ds_n = ds_late;
        lat = 0; code = 2'b11; cs1 = '1; cs2 = '1;
        for (int e = 1; e <= 20; e++) begin
            @(posedge clk); @(negedge clk);
            if (e == 1) begin cs1 = cs_n; ds_n = 1'b0; end
            if (e == 2) cs2 = cs_n;
            if (lat == 0 && dsack_n != 2'b11) begin lat = e; code = dsack_n; end
            if (lat != 0 && e >= 2) break;
        end
        as_n = 1'b1; ds_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(cs_n == '1, "R12 select release", int'(cs_n), 15);
        chk(dsack_n == 2'b11, "R12 ack release", int'(dsack_n), 3);
    endtask

    initial begin
        int lat;
        logic [NCH-1:0] c1, c2;
        logic [1:0] code;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == '1 && dsack_n == 2'b11, "R1 reset outputs", int'({cs_n, dsack_n}), 63);
        cyc(24'h000000, 3'd5, 1, 1, 0, lat, c1, c2, code);
        chk(c1 == '1 && lat == 0, "R1 no select after reset", int'(c1), 15);

        // R2 block-size sweep with base garbage below the compared range
        for (int b = 0; b < 8; b++) begin
            int s;
            logic [23:0] base, garb;
            s = (b == 0) ? 11 : (b == 1) ? 13 : (b == 2) ? 14 : b + 13;
            base = 24'hA00000;
            garb = base | (((24'd1 << s) - 1) & 24'hFFF800);
            clear_all();
            wr(0, mk(garb, 3'(b), 2'b11, 3'd0, 4'd14, 0, 2'b11, 1));
            cyc(base | ((24'd1 << s) - 1), 3'd5, 1, 1, 0, lat, c1, c2, code);
            chk(c1[0] == 1'b0 && lat == 1, "R2 inside block", int'(c1[0]), 0);
            cyc(base ^ (24'd1 << s), 3'd5, 1, 1, 0, lat, c1, c2, code);
            chk(c1[0] == 1'b1 && lat == 0, "R2 lowest compared bit", int'(c1[0]), 1);
        end

        // R3 space sweep
        for (int sp = 0; sp < 4; sp++) begin
            clear_all();
            wr(0, mk(24'h100000, 3'd7, 2'(sp), 3'd0, 4'd14, 0, 2'b11, 1));
            for (int k = 0; k < 3; k++) begin
                logic [2:0] f;
                bit cpu, exp;
                f = (k == 0) ? 3'd1 : (k == 1) ? 3'd5 : 3'd7;
                cpu = (f == 3'd7);
                exp = (sp == 0) ? cpu : (sp == 1) ? (!cpu && !f[2]) :
                      (sp == 2) ? (!cpu && f[2]) : !cpu;
                cyc(24'h123456, f, 1, 1, 0, lat, c1, c2, code);
                chk(c1[0] == !exp, "R3 space match", int'(c1[0]), int'(!exp));
            end
        end

        // R4 level sweep in CPU space
        for (int lv = 0; lv < 8; lv++) begin
            clear_all();
            wr(0, mk(24'hF00000, 3'd7, 2'b00, 3'(lv), 4'd14, 0, 2'b11, 1));
            for (int cl = 1; cl < 8; cl++) begin
                bit exp;
                exp = (lv == 0) || (lv == cl);
                cyc(24'hFFFFF0 | (24'(cl) << 1), 3'd7, 1, 1, 0, lat, c1, c2, code);
                chk(c1[0] == !exp, "R4 level match", int'(c1[0]), int'(!exp));
            end
        end

        // R5 R6 R7 termination sweep with alternating port width
        for (int t = 0; t < 16; t++) begin
            int elat;
            bit p16;
            p16 = t[0];
            clear_all();
            wr(0, mk(24'h200000, 3'd7, 2'b11, 3'd0, 4'(t), 0, 2'b11, p16));
            cyc(24'h2ABCDE, 3'd1, 1, 1, 0, lat, c1, c2, code);
            elat = (t == 15) ? 0 : (t == 14) ? 1 : t + 2;
            chk(lat == elat, (t < 14) ? "R5 wait latency" : "R6 fast or external", lat, elat);
            if (t != 15)
                chk(code == (p16 ? 2'b01 : 2'b10), "R7 port code", int'(code),
                    p16 ? 1 : 2);
            chk(c1[0] == 1'b0, "R5 select with ack", int'(c1[0]), 0);
        end

        // R9 lane sweep
        for (int ln = 1; ln < 4; ln++) begin
            clear_all();
            wr(0, mk(24'h300000, 3'd7, 2'b11, 3'd0, 4'd14, 0, 2'(ln), 0));
            for (int cb = 1; cb < 4; cb++) begin
                bit exp;
                exp = (ln[0] && cb[0]) || (ln[1] && cb[1]);
                cyc(24'h300010, 3'd5, cb[1], cb[0], 0, lat, c1, c2, code);
                chk(c1[0] == !exp, "R9 lane match", int'(c1[0]), int'(!exp));
            end
        end

        // R8 strobe timing: ch0 data-strobe timed, ch1 address-strobe timed
        clear_all();
        wr(0, mk(24'h400000, 3'd7, 2'b11, 3'd0, 4'd3, 1, 2'b11, 1));
        wr(1, mk(24'h400000, 3'd7, 2'b11, 3'd0, 4'd3, 0, 2'b11, 1));
        cyc(24'h400100, 3'd5, 1, 1, 1, lat, c1, c2, code);
        chk(c1[0] == 1'b1, "R8 data strobe select waits", int'(c1[0]), 1);
        chk(c1[1] == 1'b0, "R8 address strobe select early", int'(c1[1]), 0);
        chk(c2[0] == 1'b0, "R8 data strobe select follows", int'(c2[0]), 0);

        // R10 disabled channel, even though its other fields match
        clear_all();
        wr(2, mk(24'h500000, 3'd7, 2'b11, 3'd0, 4'd0, 0, 2'b00, 1));
        cyc(24'h500000, 3'd5, 1, 1, 0, lat, c1, c2, code);
        chk(c1 == '1, "R10 disabled select", int'(c1), 15);
        chk(lat == 0, "R10 disabled ack", lat, 0);

        // R11 overlap: ch1 8-bit with 2 waits, ch2 16-bit with 5 waits, ch3 elsewhere
        clear_all();
        wr(1, mk(24'h600000, 3'd7, 2'b11, 3'd0, 4'd2, 0, 2'b11, 0));
        wr(2, mk(24'h600000, 3'd3, 2'b11, 3'd0, 4'd5, 0, 2'b11, 1));
        wr(3, mk(24'h700000, 3'd7, 2'b11, 3'd0, 4'd0, 0, 2'b11, 1));
        cyc(24'h600004, 3'd5, 1, 1, 0, lat, c1, c2, code);
        chk(c1 == 4'b1001, "R11 all matching selects", int'(c1), 9);
        chk(lat == 4, "R11 lowest channel timing", lat, 4);
        chk(code == 2'b10, "R11 lowest channel width", int'(code), 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule